// File: doc/BRIEF.md
# Reorder-Buffer-Tagged Reservation Station

This block is the waiting area in front of one functional unit of an out-of-order core that retires through a reorder buffer. An issue port writes one instruction per clock into a free entry. The instruction carries an operation code, two source operands and a destination tag. A source operand is either a value or the 3-bit reorder buffer tag of the instruction that will produce it. The destination tag is the reorder buffer slot that will receive this entry's own result.

Each occupied entry watches the incoming result bus. When a broadcast carries a tag that an entry is waiting on, the entry takes the value. An entry whose operands are both values can be dispatched. Each cycle the lowest-numbered such entry goes to the built-in fixed-latency adder. The adder's result leaves on one of two ports, labelled with the destination tag. Arithmetic results go to an outgoing result-bus port that the surrounding core places on the common data bus. Store entries only form an effective address, base plus offset. That address goes out on a separate address port addressed to the reorder buffer, and nothing is ever written to memory. A flush empties the station and cancels any operation still inside the adder.

Top module: `rob_tag_rs`

## Requirements
- R1: At most one instruction is written per clock, into the lowest-numbered free entry. `iss_stall` is high exactly when every entry is occupied. An issue presented while `iss_stall` is high is dropped and never produces a result.
- R2: Source tags and the destination tag are 3-bit reorder buffer entry numbers. Every result leaves with the destination tag given at issue.
- R3: An occupied entry waiting on tag T takes the data of an incoming broadcast whose tag equals T. A broadcast with any other tag leaves the entry waiting, and it produces no result.
- R4: If an operand is issued pending on tag T in the same cycle that a broadcast with tag T arrives, the entry keeps the broadcast value rather than the tag. It then behaves as if the operand had been issued as a value.
- R5: An entry is ready when both operands hold values. Each cycle only the lowest-numbered ready entry is dispatched, so entries that become ready together produce results in consecutive cycles in entry order.
- R6: Operation code 0 yields a+b and code 1 yields a−b, modulo 2^32, with code 3 handled as code 0. The result is presented for one cycle, exactly LAT cycles (default 2) after the cycle in which the entry is dispatched. An entry issued with both operands as values is dispatched in the cycle after issue, if no lower entry is ready.
- R7: Operation code 2 is a store. Its address a+b is presented on the address port with its destination tag, with the same timing as R6, and never on the result-bus port.
- R8: A flush empties every entry and cancels operations inside the adder. No result from before the flush ever appears, and `iss_stall` is low in the cycle after the flush.
- R9: After reset the station is empty: `iss_stall`, `cdb_out_valid` and `addr_out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the station and cancel in-flight operations |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 2 | Operation: 0 add, 1 subtract, 2 store address, 3 add |
| iss_a_rdy | input | 1 | Operand a is a value (1) or a pending tag (0) |
| iss_a_tag | input | 3 | Producer tag for operand a |
| iss_a_val | input | 32 | Value of operand a (store base) |
| iss_b_rdy | input | 1 | Operand b is a value (1) or a pending tag (0) |
| iss_b_tag | input | 3 | Producer tag for operand b |
| iss_b_val | input | 32 | Value of operand b (store offset) |
| iss_dest | input | 3 | Reorder buffer entry receiving the result |
| iss_stall | output | 1 | No free entry; issue is dropped |
| cdb_in_valid | input | 1 | Incoming broadcast valid |
| cdb_in_tag | input | 3 | Tag of the incoming broadcast |
| cdb_in_data | input | 32 | Data of the incoming broadcast |
| cdb_out_valid | output | 1 | Arithmetic result valid |
| cdb_out_tag | output | 3 | Destination tag of the result |
| cdb_out_data | output | 32 | Result value |
| addr_out_valid | output | 1 | Store address valid |
| addr_out_tag | output | 3 | Reorder buffer entry of the store |
| addr_out_addr | output | 32 | Effective address |

## Verification
The hardest case to reach from the ports is several entries becoming ready in the same cycle, because only that shows the dispatch priority. The stimulus fills every entry with operations that all wait on one shared tag. It then releases them with a single broadcast and checks the exact output cycle of each destination tag. The same full state is used to present an issue while the station is stalled. The same-cycle capture at issue is reached by driving a broadcast and an issue that names the broadcast tag on the same clock edge. A flush is driven while one operation is inside the adder and another is still waiting, and no result from either may then appear.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_ST  = 2'd2,
    OP_AD2 = 2'd3
  } rs_op_e;
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    gnt = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        any    = 1'b1;
      end
    end
  end

  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> ((req & (gnt - 1'b1)) == '0));
endmodule

// File: rtl/rs_slot.sv
module rs_slot
  import rs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic              grant,
  input  rs_op_e            ld_op,
  input  logic              ld_a_rdy,
  input  logic [TAG_W-1:0]  ld_a_tag,
  input  logic [DATA_W-1:0] ld_a_val,
  input  logic              ld_b_rdy,
  input  logic [TAG_W-1:0]  ld_b_tag,
  input  logic [DATA_W-1:0] ld_b_val,
  input  logic [TAG_W-1:0]  ld_dest,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              busy,
  output logic              ready,
  output rs_op_e            op,
  output logic [DATA_W-1:0] a_val,
  output logic [DATA_W-1:0] b_val,
  output logic [TAG_W-1:0]  dest
);
  logic              busy_q, a_rdy_q, b_rdy_q;
  logic [TAG_W-1:0]  a_tag_q, b_tag_q, dest_q;
  logic [DATA_W-1:0] a_q, b_q;
  rs_op_e            op_q;

  // snoop events: a waiting operand sees its producer on the bus
  logic hit_a, hit_b;
  // same-cycle capture at issue
  logic byp_a, byp_b;

  assign hit_a = busy_q && !a_rdy_q && cdb_valid && (cdb_tag == a_tag_q);
  assign hit_b = busy_q && !b_rdy_q && cdb_valid && (cdb_tag == b_tag_q);
  assign byp_a = !ld_a_rdy && cdb_valid && (cdb_tag == ld_a_tag);
  assign byp_b = !ld_b_rdy && cdb_valid && (cdb_tag == ld_b_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      a_rdy_q <= 1'b0;
      b_rdy_q <= 1'b0;
      a_tag_q <= '0;
      b_tag_q <= '0;
      dest_q  <= '0;
      a_q     <= '0;
      b_q     <= '0;
      op_q    <= OP_ADD;
    end else if (flush) begin
      busy_q <= 1'b0;
    end else if (load) begin
      busy_q  <= 1'b1;
      op_q    <= ld_op;
      dest_q  <= ld_dest;
      a_tag_q <= ld_a_tag;
      b_tag_q <= ld_b_tag;
      a_rdy_q <= ld_a_rdy || byp_a;
      b_rdy_q <= ld_b_rdy || byp_b;
      a_q     <= ld_a_rdy ? ld_a_val : cdb_data;
      b_q     <= ld_b_rdy ? ld_b_val : cdb_data;
    end else begin
      if (grant) busy_q <= 1'b0;
      if (hit_a) begin
        a_rdy_q <= 1'b1;
        a_q     <= cdb_data;
      end
      if (hit_b) begin
        b_rdy_q <= 1'b1;
        b_q     <= cdb_data;
      end
    end
  end

  assign busy  = busy_q;
  assign ready = busy_q && a_rdy_q && b_rdy_q;
  assign op    = op_q;
  assign a_val = a_q;
  assign b_val = b_q;
  assign dest  = dest_q;

  a_r3_capture_a: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && !flush) |=> (a_rdy_q && a_q == $past(cdb_data)));
  a_r3_capture_b: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_b && !flush) |=> (b_rdy_q && b_q == $past(cdb_data)));
  a_r3_keep_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !a_rdy_q && !hit_a && !flush) |=> !a_rdy_q);
  a_r4_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
    (load && byp_a && !flush) |=> (a_rdy_q && a_q == $past(cdb_data)));
  a_r5_grant_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !load) |=> !busy_q);
  a_r1_load_only_free: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);
endmodule

// File: rtl/rs_exec.sv
module rs_exec
  import rs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  rs_op_e            in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [TAG_W-1:0]  in_dest,
  output logic              out_valid,
  output logic              out_store,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data
);
  function automatic logic [DATA_W-1:0] fu_calc(rs_op_e o, logic [DATA_W-1:0] x,
                                                logic [DATA_W-1:0] y);
    if (o == OP_SUB) return x - y;
    return x + y;
  endfunction

  logic [LAT-1:0]    v_q, st_q;
  logic [TAG_W-1:0]  tag_q [LAT];
  logic [DATA_W-1:0] dat_q [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= '0;
      st_q <= '0;
      for (int g = 0; g < LAT; g++) begin
        tag_q[g] <= '0;
        dat_q[g] <= '0;
      end
    end else begin
      v_q[0]   <= in_valid && !flush;
      st_q[0]  <= (in_op == OP_ST);
      tag_q[0] <= in_dest;
      dat_q[0] <= fu_calc(in_op, in_a, in_b);
      for (int g = 1; g < LAT; g++) begin
        v_q[g]   <= v_q[g-1] && !flush;
        st_q[g]  <= st_q[g-1];
        tag_q[g] <= tag_q[g-1];
        dat_q[g] <= dat_q[g-1];
      end
    end
  end

  assign out_valid = v_q[LAT-1];
  assign out_store = st_q[LAT-1];
  assign out_tag   = tag_q[LAT-1];
  assign out_data  = dat_q[LAT-1];

  a_r6_enter_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flush) |=> v_q[0]);
  a_r8_flush_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
endmodule

// File: rtl/rob_tag_rs.sv
module rob_tag_rs
  import rs_pkg::*;
#(
  parameter int N_ENT  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              iss_valid,
  input  logic [1:0]        iss_op,
  input  logic              iss_a_rdy,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic              iss_b_rdy,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic [DATA_W-1:0] iss_b_val,
  input  logic [TAG_W-1:0]  iss_dest,
  output logic              iss_stall,
  input  logic              cdb_in_valid,
  input  logic [TAG_W-1:0]  cdb_in_tag,
  input  logic [DATA_W-1:0] cdb_in_data,
  output logic              cdb_out_valid,
  output logic [TAG_W-1:0]  cdb_out_tag,
  output logic [DATA_W-1:0] cdb_out_data,
  output logic              addr_out_valid,
  output logic [TAG_W-1:0]  addr_out_tag,
  output logic [DATA_W-1:0] addr_out_addr
);
  logic [N_ENT-1:0]  slot_busy, slot_ready, free_gnt, disp_gnt, slot_load;
  logic              free_any, disp_any, iss_fire;
  rs_op_e            slot_op [N_ENT];
  logic [DATA_W-1:0] slot_a [N_ENT];
  logic [DATA_W-1:0] slot_b [N_ENT];
  logic [TAG_W-1:0]  slot_dest [N_ENT];
  rs_op_e            d_op;
  logic [DATA_W-1:0] d_a, d_b;
  logic [TAG_W-1:0]  d_dest;
  logic              x_valid, x_store;
  logic [TAG_W-1:0]  x_tag;
  logic [DATA_W-1:0] x_data;

  rs_pick #(.N(N_ENT)) u_free_pick (
    .clk(clk), .rst_n(rst_n), .req(~slot_busy), .gnt(free_gnt), .any(free_any)
  );

  assign iss_stall = !free_any;
  assign iss_fire  = iss_valid && free_any;
  assign slot_load = iss_fire ? free_gnt : '0;

  for (genvar i = 0; i < N_ENT; i++) begin : g_slot
    rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .load(slot_load[i]), .grant(disp_gnt[i]),
      .ld_op(rs_op_e'(iss_op)),
      .ld_a_rdy(iss_a_rdy), .ld_a_tag(iss_a_tag), .ld_a_val(iss_a_val),
      .ld_b_rdy(iss_b_rdy), .ld_b_tag(iss_b_tag), .ld_b_val(iss_b_val),
      .ld_dest(iss_dest),
      .cdb_valid(cdb_in_valid), .cdb_tag(cdb_in_tag), .cdb_data(cdb_in_data),
      .busy(slot_busy[i]), .ready(slot_ready[i]), .op(slot_op[i]),
      .a_val(slot_a[i]), .b_val(slot_b[i]), .dest(slot_dest[i])
    );
  end

  rs_pick #(.N(N_ENT)) u_disp_pick (
    .clk(clk), .rst_n(rst_n), .req(slot_ready), .gnt(disp_gnt), .any(disp_any)
  );

  always_comb begin
    d_op   = OP_ADD;
    d_a    = '0;
    d_b    = '0;
    d_dest = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (disp_gnt[i]) begin
        d_op   = slot_op[i];
        d_a    = slot_a[i];
        d_b    = slot_b[i];
        d_dest = slot_dest[i];
      end
    end
  end

  rs_exec #(.DATA_W(DATA_W), .TAG_W(TAG_W), .LAT(LAT)) u_exec (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(disp_any), .in_op(d_op), .in_a(d_a), .in_b(d_b), .in_dest(d_dest),
    .out_valid(x_valid), .out_store(x_store), .out_tag(x_tag), .out_data(x_data)
  );

  assign cdb_out_valid  = x_valid && !x_store;
  assign cdb_out_tag    = x_tag;
  assign cdb_out_data   = x_data;
  assign addr_out_valid = x_valid && x_store;
  assign addr_out_tag   = x_tag;
  assign addr_out_addr  = x_data;

  a_r7_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(cdb_out_valid && addr_out_valid));
  a_r1_stall_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_stall && !flush) |=> ($countones(slot_busy) <= $past($countones(slot_busy))));
  a_r1_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_load));
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!iss_stall && !cdb_out_valid && !addr_out_valid));
endmodule

// File: tb/rob_tag_rs_bench.sv
`timescale 1ns/1ps
module rob_tag_rs_bench;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic iss_valid = 1'b0;
  logic [1:0] iss_op = '0;
  logic iss_a_rdy = 1'b0, iss_b_rdy = 1'b0;
  logic [2:0] iss_a_tag = '0, iss_b_tag = '0, iss_dest = '0;
  logic [31:0] iss_a_val = '0, iss_b_val = '0;
  logic iss_stall;
  logic cdb_in_valid = 1'b0;
  logic [2:0] cdb_in_tag = '0;
  logic [31:0] cdb_in_data = '0;
  logic cdb_out_valid, addr_out_valid;
  logic [2:0] cdb_out_tag, addr_out_tag;
  logic [31:0] cdb_out_data, addr_out_addr;

  always #2.5 clk = ~clk;

  rob_tag_rs u_rob_tag_rs (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_a_rdy(iss_a_rdy), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
    .iss_b_rdy(iss_b_rdy), .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
    .iss_dest(iss_dest), .iss_stall(iss_stall),
    .cdb_in_valid(cdb_in_valid), .cdb_in_tag(cdb_in_tag), .cdb_in_data(cdb_in_data),
    .cdb_out_valid(cdb_out_valid), .cdb_out_tag(cdb_out_tag), .cdb_out_data(cdb_out_data),
    .addr_out_valid(addr_out_valid), .addr_out_tag(addr_out_tag),
    .addr_out_addr(addr_out_addr)
  );

  int cyc = 0;
  int n_chk = 0, n_fail = 0, out_cnt = 0, last_cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard keyed by destination tag
  logic [31:0] sb_val [int];
  bit          sb_st  [int];
  int          sb_cyc [int];
  string       sb_req [int];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_res(input int tag, input logic [31:0] v, input bit st,
                            input int c, input string req);
    sb_val[tag] = v;
    sb_st[tag]  = st;
    sb_cyc[tag] = c;
    sb_req[tag] = req;
  endtask

  task automatic match(input int tag, input logic [31:0] v, input bit st);
    out_cnt++;
    if (!sb_val.exists(tag)) begin
      check(1'b0, "R1/R3/R8", "unexpected result tag", tag, -1);
    end else begin
      check(v == sb_val[tag], sb_req[tag], "result value", v, sb_val[tag]);
      check(st == sb_st[tag], "R7", "result port (1=address)", st, sb_st[tag]);
      check(cyc == sb_cyc[tag], sb_req[tag], "result cycle", cyc, sb_cyc[tag]);
      sb_val.delete(tag);
      sb_st.delete(tag);
      sb_cyc.delete(tag);
      sb_req.delete(tag);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (cdb_out_valid) match(int'(cdb_out_tag), cdb_out_data, 1'b0);
      if (addr_out_valid) match(int'(addr_out_tag), addr_out_addr, 1'b1);
    end
  end

  // all tasks start and end at a falling edge
  task automatic issue(input int op, input logic [31:0] a, input bit ar, input int at,
                       input logic [31:0] b, input bit br, input int bt, input int dest);
    iss_valid = 1'b1;
    iss_op    = op[1:0];
    iss_a_val = a;  iss_a_rdy = ar; iss_a_tag = at[2:0];
    iss_b_val = b;  iss_b_rdy = br; iss_b_tag = bt[2:0];
    iss_dest  = dest[2:0];
    @(negedge clk);
    iss_valid = 1'b0;
    last_cyc  = cyc;
  endtask

  task automatic bcast(input int tag, input logic [31:0] d);
    cdb_in_valid = 1'b1;
    cdb_in_tag   = tag[2:0];
    cdb_in_data  = d;
    @(negedge clk);
    cdb_in_valid = 1'b0;
    last_cyc     = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(!iss_stall, "R9", "stall after reset", iss_stall, 0);
    check(!cdb_out_valid && !addr_out_valid, "R9", "outputs after reset",
          cdb_out_valid | addr_out_valid, 0);

    // R6 add and subtract with ready operands; R2 tag carried
    issue(0, 32'd10, 1, 0, 32'd20, 1, 0, 1);
    expect_res(1, 32'd30, 0, last_cyc + LAT, "R6");
    issue(1, 32'd100, 1, 0, 32'd1, 1, 0, 2);
    expect_res(2, 32'd99, 0, last_cyc + LAT, "R6");
    issue(1, 32'd5, 1, 0, 32'd7, 1, 0, 3);
    expect_res(3, 32'hFFFF_FFFE, 0, last_cyc + LAT, "R6");
    issue(3, 32'hFFFF_FFFF, 1, 0, 32'd2, 1, 0, 5);
    expect_res(5, 32'd1, 0, last_cyc + LAT, "R6");
    // R7 store address
    issue(2, 32'h1000, 1, 0, 32'h20, 1, 0, 4);
    expect_res(4, 32'h1020, 1, last_cyc + LAT, "R7");
    idle(5);

    // R3 pending operand, wrong tag first
    issue(0, 32'd0, 0, 5, 32'd3, 1, 0, 6);
    idle(2);
    base = out_cnt;
    bcast(6, 32'd999);
    idle(4);
    check(out_cnt == base, "R3", "outputs after non-matching tag", out_cnt, base);
    bcast(5, 32'd40);
    expect_res(6, 32'd43, 0, last_cyc + LAT, "R3");
    idle(4);
    // R3 both operands pending on different tags
    issue(1, 32'd0, 0, 1, 32'd0, 0, 2, 7);
    bcast(1, 32'd500);
    idle(2);
    bcast(2, 32'd123);
    expect_res(7, 32'd377, 0, last_cyc + LAT, "R3");
    idle(5);

    // R4 broadcast in the issue cycle
    cdb_in_valid = 1'b1; cdb_in_tag = 3'd4; cdb_in_data = 32'd50;
    issue(1, 32'd0, 0, 4, 32'd8, 1, 0, 0);
    cdb_in_valid = 1'b0;
    expect_res(0, 32'd42, 0, last_cyc + LAT, "R4");
    idle(5);

    // R1 fill all, stall, dropped issue; R5 priority order
    for (int i = 0; i < 4; i++) issue(0, 32'(100 * i), 1, 0, 32'd0, 0, 3, i);
    check(iss_stall, "R1", "stall when full", iss_stall, 1);
    base = out_cnt;
    issue(0, 32'd1, 1, 0, 32'd1, 1, 0, 5);
    bcast(3, 32'd7);
    for (int i = 0; i < 4; i++) expect_res(i, 32'(100 * i + 7), 0, last_cyc + LAT + i, "R5");
    idle(8);
    check(out_cnt == base + 4, "R1", "results after dropped issue", out_cnt, base + 4);
    check(!iss_stall, "R1", "stall after drain", iss_stall, 0);

    // R8 flush with one op in the unit and one waiting
    base = out_cnt;
    issue(0, 32'd1, 1, 0, 32'd2, 1, 0, 1);
    issue(0, 32'd0, 0, 2, 32'd2, 1, 0, 2);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check(!iss_stall, "R8", "stall after flush", iss_stall, 0);
    bcast(2, 32'd9);
    idle(6);
    check(out_cnt == base, "R8", "results after flush", out_cnt, base);
    issue(0, 32'd6, 1, 0, 32'd6, 1, 0, 3);
    expect_res(3, 32'd12, 0, last_cyc + LAT, "R8");
    idle(5);

    check(sb_val.size() == 0, "R2", "results never produced", sb_val.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule